// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Control Port

This block is the digital side of the serial control port of a delta-sigma converter. An SPI-style master drives a serial clock, a data input and an active-low select. The block returns data on one output that also carries the result-ready flag. The serial clock is oversampled by the system clock. Input bits are taken on rising serial-clock edges and output bits change on falling edges. The serial clock idles high and every field is sent MSB first.

Each access starts with an 8-bit command byte. The command is never stored for reading back. It picks one of the on-chip words and sets the direction of the next access. The conversion engine is outside the block: it pulses a completion strobe together with a 24-bit result. A continuous-read command makes each new result stream out with no further command. A run of 40 ones on the data input returns all interface state to its defaults. The port also works with select tied low permanently.

Command byte layout:

| Bit | Meaning |
|-----|---------|
| 7 | Must be 0 |
| 6 | 1 = read, 0 = write |
| 5:3 | Word select |
| 2 | Continuous-read request |
| 1:0 | Zero |

Word select values:

| Select | Word |
|--------|------|
| 0 | Status, 8 bits: bit 7 is the not-ready flag, the other bits read 0 |
| 1 | Mode |
| 2 | Configuration (bit 23 is the chop enable) |
| 3 | Result |
| 4 | Offset |

Top module: `adc_serial_port`

## Requirements
- R1: After reset the words hold these values: status 0x80, mode 0x000040, configuration 0x000008, result 0x000000, offset 0x800000. `dout_rdy` is high.
- R2: A command byte with bit 7 set is dropped, and the next byte is taken as a new command. A read of select 5, 6 or 7 returns 24 zero bits.
- R3: A write command (bit 6 = 0) to select 1, 2 or 4 is followed by 24 data bits, MSB first. The new value shows on `mode_word`, `conf_word` or `offset_word` once the last bit has been taken.
- R4: A read command (bit 6 = 1) shifts out the selected word MSB first. One bit is driven after each falling serial-clock edge. Status reads are 8 bits long and all other reads are 24 bits long.
- R5: Writes to select 0 (8 data bits) and to select 3 (24 data bits) are accepted on the wire but change nothing.
- R6: A completion strobe latches `conv_result` into the result word. It clears the not-ready flag, so `dout_rdy` is low while no transfer is under way.
- R7: Starting a result read sets the not-ready flag. `dout_rdy` then stays high between transfers until the next completion strobe.
- R8: When mode bit 20 is set, a result read is 32 bits long. It carries the 24-bit result followed by the status byte as it stood when the read began.
- R9: Command 0x5C enters continuous-read mode. From then on, whenever the flag is low, the first falling serial-clock edge starts shifting out the result (24 bits, or 32 when mode bit 20 is set) with no command.
- R10: In continuous-read mode, if 0x58 is clocked in during the first 8 bits of a result readout, that readout completes and the port then waits for commands again.
- R11: 40 consecutive ones taken on rising edges while select is low restore every word and the port state to the R1 values. A 0 after 39 ones restores nothing.
- R12: Raising `cs_n` abandons a partly received command. After select falls again, the next 8 bits are taken as a fresh command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master, idles high |
| din | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low select |
| conv_done | input | 1 | One-cycle completion strobe from the conversion engine |
| conv_result | input | 24 | Result that accompanies the strobe |
| dout_rdy | output | 1 | Serial data out during reads, not-ready flag otherwise |
| mode_word | output | 24 | Current mode word |
| conf_word | output | 24 | Current configuration word |
| offset_word | output | 24 | Current offset word |

## Verification
The serial inputs pass through two synchronizer stages and one edge register. The port state therefore changes about three system clocks after a serial-clock transition, and an output bit is valid about four clocks after a falling edge. The bench holds each serial-clock half period for six clocks. It samples `dout_rdy` in the last clock before it raises the serial clock, so every bit has settled when it is read. A completion strobe reaches `dout_rdy` one clock later, and the bench reads it two clocks after the strobe. Register ports are read once the final rising edge of a write has been followed by a full six-clock high phase.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    localparam int REG_W   = 24;
    localparam int STAT_W  = 8;
    localparam int FRAME_W = REG_W + STAT_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam logic [2:0] SEL_STAT = 3'd0;
    localparam logic [2:0] SEL_MODE = 3'd1;
    localparam logic [2:0] SEL_CONF = 3'd2;
    localparam logic [2:0] SEL_DATA = 3'd3;
    localparam logic [2:0] SEL_OFFS = 3'd4;

    localparam logic [REG_W-1:0] MODE_INIT = 24'h000040;
    localparam logic [REG_W-1:0] CONF_INIT = 24'h000008;
    localparam logic [REG_W-1:0] DATA_INIT = 24'h000000;
    localparam logic [REG_W-1:0] OFFS_INIT = 24'h800000;

    localparam logic [7:0] CMD_STREAM_OFF = 8'h58;
    localparam int         MODE_APPEND_BIT = 20;

    typedef enum logic [1:0] {
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_STREAM
    } port_st_e;

    typedef struct packed {
        logic       hold;
        logic       rd;
        logic [2:0] sel;
        logic       stream;
        logic [1:0] pad;
    } cmd_t;

    function automatic logic [CNT_W-1:0] frame_len(input logic [2:0] sel, input logic append);
        if (sel == SEL_STAT)
            return CNT_W'(STAT_W);
        else if (sel == SEL_DATA && append)
            return CNT_W'(FRAME_W);
        else
            return CNT_W'(REG_W);
    endfunction

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic din,
    input  logic cs_n,
    output logic din_s,
    output logic cs_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic [STAGES-1:0] sclk_ff, din_ff, cs_ff;
    logic              sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_ff   <= '1;
            din_ff    <= '0;
            cs_ff     <= '1;
            sclk_prev <= 1'b1;
        end else begin
            sclk_ff   <= {sclk_ff[STAGES-2:0], sclk};
            din_ff    <= {din_ff[STAGES-2:0], din};
            cs_ff     <= {cs_ff[STAGES-2:0], cs_n};
            sclk_prev <= sclk_ff[STAGES-1];
        end
    end

    assign din_s     = din_ff[STAGES-1];
    assign cs_s      = cs_ff[STAGES-1];
    assign sclk_rise = sclk_ff[STAGES-1] & ~sclk_prev;
    assign sclk_fall = ~sclk_ff[STAGES-1] & sclk_prev;

endmodule

// File: rtl/adc_sp_ones.sv
module adc_sp_ones #(
    parameter int RUN = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic din_s,
    input  logic cs_s,
    output logic hit
);
    localparam int RW = $clog2(RUN + 1);
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || cs_s) begin
            run <= '0;
        end else if (rise) begin
            if (!din_s || run == RW'(RUN - 1))
                run <= '0;
            else
                run <= run + 1'b1;
        end
    end

    assign hit = rise && !cs_s && din_s && (run == RW'(RUN - 1));

    // R11: the run counter never passes the reset length
    p_run_bound_r11: assert property (@(posedge clk) disable iff (rst)
        run < RW'(RUN));

    // R11: a detected run restarts the count
    p_hit_restart_r11: assert property (@(posedge clk) disable iff (rst)
        hit |=> run == '0);

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int RESET_ONES  = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             din,
    input  logic             cs_n,
    input  logic             conv_done,
    input  logic [REG_W-1:0] conv_result,
    output logic             dout_rdy,
    output logic [REG_W-1:0] mode_word,
    output logic [REG_W-1:0] conf_word,
    output logic [REG_W-1:0] offset_word
);
    logic din_s, cs_s, rise, fall, soft_hit;

    adc_sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .din(din), .cs_n(cs_n),
        .din_s(din_s), .cs_s(cs_s), .sclk_rise(rise), .sclk_fall(fall)
    );

    adc_sp_ones #(.RUN(RESET_ONES)) u_ones (
        .clk(clk), .rst(rst), .rise(rise), .din_s(din_s), .cs_s(cs_s), .hit(soft_hit)
    );

    port_st_e             state;
    logic [REG_W-1:0]     in_sr, data_r, mode_r, conf_r, offs_r;
    logic [FRAME_W-1:0]   out_sr, rd_word, stream_word;
    logic [CNT_W-1:0]     bit_cnt, len;
    logic [2:0]           sel_r;
    logic                 rdy_n, dout_q, streaming, append;
    logic [STAT_W-1:0]    status_b;
    logic [REG_W-1:0]     wr_word;
    cmd_t                 cmd_now;

    assign append   = mode_r[MODE_APPEND_BIT];
    assign status_b = {rdy_n, {(STAT_W-1){1'b0}}};
    assign cmd_now  = cmd_t'({in_sr[6:0], din_s});
    assign wr_word  = {in_sr[REG_W-2:0], din_s};
    assign stream_word = append ? {data_r, status_b} : {data_r, {STAT_W{1'b0}}};

    always_comb begin
        case (cmd_now.sel)
            SEL_STAT: rd_word = {status_b, {REG_W{1'b0}}};
            SEL_MODE: rd_word = {mode_r, {STAT_W{1'b0}}};
            SEL_CONF: rd_word = {conf_r, {STAT_W{1'b0}}};
            SEL_DATA: rd_word = stream_word;
            SEL_OFFS: rd_word = {offs_r, {STAT_W{1'b0}}};
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || soft_hit) begin
            state     <= ST_CMD;
            in_sr     <= '0;
            out_sr    <= '0;
            bit_cnt   <= '0;
            len       <= '0;
            sel_r     <= SEL_STAT;
            dout_q    <= 1'b1;
            streaming <= 1'b0;
            rdy_n     <= 1'b1;
            data_r    <= DATA_INIT;
            mode_r    <= MODE_INIT;
            conf_r    <= CONF_INIT;
            offs_r    <= OFFS_INIT;
        end else begin
            if (cs_s) begin
                bit_cnt <= '0;
                state   <= streaming ? ST_STREAM : ST_CMD;
            end else if (rise) begin
                in_sr <= wr_word;
                case (state)
                    ST_CMD: begin
                        if (bit_cnt == CNT_W'(7)) begin
                            bit_cnt <= '0;
                            if (!cmd_now.hold) begin
                                sel_r <= cmd_now.sel;
                                if (cmd_now.rd && cmd_now.sel == SEL_DATA && cmd_now.stream) begin
                                    streaming <= 1'b1;
                                    state     <= ST_STREAM;
                                end else if (cmd_now.rd) begin
                                    state  <= ST_RD;
                                    len    <= frame_len(cmd_now.sel, append);
                                    out_sr <= rd_word;
                                    if (cmd_now.sel == SEL_DATA)
                                        rdy_n <= 1'b1;
                                end else begin
                                    state <= ST_WR;
                                    len   <= frame_len(cmd_now.sel, 1'b0);
                                end
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_WR: begin
                        if (bit_cnt == len - 1'b1) begin
                            bit_cnt <= '0;
                            state   <= ST_CMD;
                            case (sel_r)
                                SEL_MODE: mode_r <= wr_word;
                                SEL_CONF: conf_r <= wr_word;
                                SEL_OFFS: offs_r <= wr_word;
                                default: ;
                            endcase
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_RD: begin
                        if (bit_cnt == CNT_W'(7) && streaming && cmd_now == cmd_t'(CMD_STREAM_OFF))
                            streaming <= 1'b0;
                        if (bit_cnt == len - 1'b1) begin
                            bit_cnt <= '0;
                            state   <= (streaming && !(bit_cnt == CNT_W'(7) &&
                                        cmd_now == cmd_t'(CMD_STREAM_OFF))) ? ST_STREAM : ST_CMD;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (fall) begin
                if (state == ST_RD) begin
                    dout_q <= out_sr[FRAME_W-1];
                    out_sr <= out_sr << 1;
                end else if (state == ST_STREAM && !rdy_n) begin
                    dout_q  <= stream_word[FRAME_W-1];
                    out_sr  <= stream_word << 1;
                    len     <= frame_len(SEL_DATA, append);
                    bit_cnt <= '0;
                    rdy_n   <= 1'b1;
                    state   <= ST_RD;
                end
            end
            if (conv_done) begin
                data_r <= conv_result;
                rdy_n  <= 1'b0;
            end
        end
    end

    assign dout_rdy    = (state == ST_RD && !cs_s) ? dout_q : rdy_n;
    assign mode_word   = mode_r;
    assign conf_word   = conf_r;
    assign offset_word = offs_r;

    // R6: a completion strobe clears the not-ready flag
    p_done_ready_r6: assert property (@(posedge clk) disable iff (rst)
        conv_done && !soft_hit |=> !rdy_n);

    // R12: a raised select leaves no transfer in progress
    p_cs_idle_r12: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> (state != ST_RD && bit_cnt == '0));

    // R4: a readout never counts past its own length
    p_rd_bound_r4: assert property (@(posedge clk) disable iff (rst)
        state == ST_RD |-> bit_cnt < len);

    // R10: continuous-read mode is left only from a readout or a serial reset
    p_stream_exit_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(streaming) && !$past(soft_hit) |-> $past(state) == ST_RD);

endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1, din = 1'b0, cs_n = 1'b0, conv_done = 1'b0;
    logic [23:0] conv_result = '0;
    logic        dout_rdy;
    logic [23:0] mode_word, conf_word, offset_word;
    int          n_chk = 0, n_fail = 0;
    logic [31:0] v;

    always #10 clk = ~clk;

    adc_serial_port u_dut (
        .clk(clk), .rst(rst), .sclk(sclk), .din(din), .cs_n(cs_n),
        .conv_done(conv_done), .conv_result(conv_result), .dout_rdy(dout_rdy),
        .mode_word(mode_word), .conf_word(conf_word), .offset_word(offset_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic shift(input int n, input logic [31:0] wv, output logic [31:0] rv);
        rv = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk) sclk = 1'b0; din = wv[i];
            repeat (6) @(negedge clk);
            rv[i] = dout_rdy;
            sclk = 1'b1;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic rd(input logic [7:0] cmd, input int n, output logic [31:0] rv);
        logic [31:0] dummy;
        shift(8, {24'b0, cmd}, dummy);
        shift(n, 32'b0, rv);
    endtask

    task automatic wr(input logic [7:0] cmd, input int n, input logic [31:0] val);
        logic [31:0] dummy;
        shift(8, {24'b0, cmd}, dummy);
        shift(n, val, dummy);
    endtask

    task automatic conv(input logic [23:0] res);
        @(negedge clk) conv_done = 1'b1; conv_result = res;
        @(negedge clk) conv_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 dout idle", {31'b0, dout_rdy}, 32'h1);
        chk("R1 mode", {8'b0, mode_word}, 32'h000040);
        chk("R1 conf", {8'b0, conf_word}, 32'h000008);
        chk("R1 offset", {8'b0, offset_word}, 32'h800000);
        rd(8'h40, 8, v);  chk("R1 status read", v, 32'h80);
        rd(8'h58, 24, v); chk("R1 result read", v, 32'h0);
    endtask

    task automatic t_regs;
        rd(8'h48, 24, v); chk("R4 mode read", v, 32'h000040);
        wr(8'h10, 24, 32'h800008); chk("R3 conf write", {8'b0, conf_word}, 32'h800008);
        rd(8'h50, 24, v); chk("R4 conf read", v, 32'h800008);
        wr(8'h20, 24, 32'h123456); chk("R3 offset write", {8'b0, offset_word}, 32'h123456);
        rd(8'h68, 24, v); chk("R2 unused select", v, 32'h0);
    endtask

    task automatic t_ignore;
        wr(8'h18, 24, 32'hFFFFFF);
        rd(8'h58, 24, v); chk("R5 result write ignored", v, 32'h0);
        wr(8'h00, 8, 32'h00);
        rd(8'h40, 8, v);  chk("R5 status write ignored", v, 32'h80);
        shift(8, 32'hC8, v);
        rd(8'h48, 24, v); chk("R2 bit7 command dropped", v, 32'h000040);
    endtask

    task automatic t_conv;
        conv(24'h3C5A96);
        chk("R6 ready low", {31'b0, dout_rdy}, 32'h0);
        rd(8'h58, 24, v); chk("R6 result value", v, 32'h3C5A96);
        chk("R7 ready high after read", {31'b0, dout_rdy}, 32'h1);
        rd(8'h40, 8, v);  chk("R7 status after read", v, 32'h80);
    endtask

    task automatic t_append;
        wr(8'h08, 24, 32'h100040);
        conv(24'hABCDEF);
        rd(8'h58, 32, v); chk("R8 result plus status", v, 32'hABCDEF00);
        rd(8'h58, 32, v); chk("R8 repeat not ready", v, 32'hABCDEF80);
        wr(8'h08, 24, 32'h000040);
        chk("R3 mode restored", {8'b0, mode_word}, 32'h000040);
    endtask

    task automatic t_stream;
        shift(8, 32'h5C, v);
        chk("R9 no result yet", {31'b0, dout_rdy}, 32'h1);
        conv(24'hA5C3E1);
        chk("R9 ready low", {31'b0, dout_rdy}, 32'h0);
        shift(24, 32'h0, v); chk("R9 first streamed", v, 32'hA5C3E1);
        chk("R9 ready high after stream", {31'b0, dout_rdy}, 32'h1);
        conv(24'h0F0F0F);
        shift(24, 32'h580000, v); chk("R10 last streamed", v, 32'h0F0F0F);
        conv(24'h111111);
        rd(8'h40, 8, v); chk("R10 command after exit", v, 32'h00);
        rd(8'h58, 24, v); chk("R10 result by command", v, 32'h111111);
    endtask

    task automatic t_ones;
        shift(32, 32'hFFFFFFFF, v);
        shift(8, 32'hFE, v);
        chk("R11 39 ones no reset", {8'b0, offset_word}, 32'h123456);
        shift(32, 32'hFFFFFFFF, v);
        shift(8, 32'hFF, v);
        chk("R11 offset restored", {8'b0, offset_word}, 32'h800000);
        chk("R11 conf restored", {8'b0, conf_word}, 32'h000008);
        rd(8'h40, 8, v); chk("R11 status restored", v, 32'h80);
    endtask

    task automatic t_cs;
        shift(4, 32'h4, v);
        @(negedge clk) cs_n = 1'b1;
        repeat (8) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        rd(8'h48, 24, v); chk("R12 fresh command", v, 32'h000040);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset;
        t_regs;
        t_ignore;
        t_conv;
        t_append;
        t_stream;
        t_ones;
        t_cs;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule